// File: doc/BRIEF.md
# Errored Field Counter with Sensitivity Mask

This block counts video fields in which the outgoing error-detection packet carries at least one error flag that the host has chosen to watch. Once per field, a strobe presents sixteen error flags and a separate packet-checksum error flag. A sixteen-bit mask selects the flags that matter; its bits are active low. A single active-high bit enables the checksum flag. A field with any selected flag set adds one to the count, however many flags are raised in it.

A two-bit mode input selects one of four behaviours: free counting, holding the count at zero, clearing on every host read, and freezing the count. The count stops at its all-ones value and does not wrap. The host reads the count through a request/response port. The port takes the whole count into a register in one clock edge, so a read never sees a value that is half updated.

Top module: `errfield_counter`

## Requirements
- R1: After a synchronous reset the internal count is zero, `rd_valid` is low and `rd_count` is zero.
- R2: When `field_done` is high and at least one enabled flag is set, the count rises by exactly one. This holds whether one flag or all sixteen are set.
- R3: Flag `err_flags[i]` is enabled when `sens_n[i]` is 0. When `sens_n[i]` is 1, that flag is ignored.
- R4: `crc_err` is enabled when `crc_sens` is 1 and ignored when `crc_sens` is 0.
- R5: Flag inputs have no effect in cycles where `field_done` is low.
- R6: Mode 2'b00 counts freely. Mode 2'b01 holds the count at zero, and fields that arrive during it are lost.
- R7: In mode 2'b10 a read returns the current count and clears it in the same edge. If a counted field lands in that edge, the count becomes one.
- R8: In mode 2'b11 the count is frozen. Reads return it and do not change it.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.
- R10: A read request sampled at a clock edge sets `rd_valid` high for exactly the next cycle. In that same edge, `rd_count` is loaded with all CNT_W bits of the count as they stood at the edge. `rd_count` then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_done | input | 1 | One-cycle strobe: the flags belong to a finished field |
| err_flags | input | 16 | Error flags of the outgoing packet |
| crc_err | input | 1 | Packet checksum error flag |
| sens_n | input | 16 | Per-flag sensitivity, 0 = counted |
| crc_sens | input | 1 | Checksum flag sensitivity, 1 = counted |
| mode | input | 2 | 00 free, 01 hold zero, 10 clear on read, 11 freeze |
| rd_req | input | 1 | Read request strobe |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_count | output | CNT_W | Captured count |

## Verification
A field strobe sampled at edge N is reduced to a registered hit flag at that edge. The count changes at edge N+1, so the change shows up in a read requested from the following cycle onward. A read request sampled at edge M produces `rd_count` and `rd_valid` right after M. The bench drives inputs on falling edges and waits one extra falling edge after each strobe before it reads. It samples the read outputs on the falling edge that follows the request. Saturation is checked on a second instance built with a four-bit count.

// File: rtl/efc_pkg.sv
package efc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'b00,
    MODE_HOLD0  = 2'b01,
    MODE_RDCLR  = 2'b10,
    MODE_FREEZE = 2'b11
  } efc_mode_e;
endpackage

// File: rtl/efc_hit_detect.sv
module efc_hit_detect #(
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_done,
  input  logic [FLAG_W-1:0] err_flags,
  input  logic              crc_err,
  input  logic [FLAG_W-1:0] sens_n,
  input  logic              crc_sens,
  output logic              hit_q
);
  logic [FLAG_W-1:0] sel;
  logic              any_hit;

  // active-low mask per flag, active-high for checksum
  always_comb begin
    sel     = err_flags & ~sens_n;
    any_hit = (|sel) | (crc_err & crc_sens);
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= field_done & any_hit;
  end

  p_nostrobe_r5: assert property (@(posedge clk) disable iff (rst)
    !field_done |=> !hit_q);
endmodule

// File: rtl/efc_count_core.sv
module efc_count_core
  import efc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [1:0]       mode,
  input  logic             rd_req,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  efc_mode_e        md;
  logic             at_max;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    md     = efc_mode_e'(mode);
    at_max = (cnt_q == CNT_MAX);
    cnt_d  = cnt_q;
    unique case (md)
      MODE_FREE:   if (hit && !at_max) cnt_d = cnt_q + CNT_ONE;
      MODE_HOLD0:  cnt_d = '0;
      MODE_RDCLR: begin
        if (rd_req)               cnt_d = hit ? CNT_ONE : '0;
        else if (hit && !at_max)  cnt_d = cnt_q + CNT_ONE;
      end
      MODE_FREEZE: cnt_d = cnt_q;
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (cnt_q == '0));
  p_rdclr_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && rd_req) |=> (cnt_q <= CNT_ONE));
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> $stable(cnt_q));
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && (mode == 2'b00 || (mode == 2'b10 && !rd_req)))
      |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/efc_read_port.sv
module efc_read_port #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [CNT_W-1:0] cnt,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_count
);
  // whole-word capture in one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_count <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_count <= cnt;
    end
  end

  p_capture_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (rd_valid && rd_count == $past(cnt)));
  p_holddata_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && $stable(rd_count)));
endmodule

// File: rtl/errfield_counter.sv
module errfield_counter #(
  parameter int FLAG_W = 16,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_done,
  input  logic [FLAG_W-1:0] err_flags,
  input  logic              crc_err,
  input  logic [FLAG_W-1:0] sens_n,
  input  logic              crc_sens,
  input  logic [1:0]        mode,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_count
);
  logic             hit_q;
  logic [CNT_W-1:0] cnt_q;

  efc_hit_detect #(.FLAG_W(FLAG_W)) u_hit (
    .clk(clk), .rst(rst), .field_done(field_done), .err_flags(err_flags),
    .crc_err(crc_err), .sens_n(sens_n), .crc_sens(crc_sens), .hit_q(hit_q)
  );

  efc_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hit(hit_q), .mode(mode), .rd_req(rd_req),
    .cnt_q(cnt_q)
  );

  efc_read_port #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .cnt(cnt_q),
    .rd_valid(rd_valid), .rd_count(rd_count)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_count == '0));
endmodule

// File: tb/errfield_counter_tb.sv
module errfield_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        field_done = 1'b0;
  logic [15:0] err_flags = '0;
  logic        crc_err = 1'b0;
  logic [15:0] sens_n = 16'hFFFF;
  logic        crc_sens = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        rd_req = 1'b0;
  logic        rd_valid, rd_valid_s;
  logic [23:0] rd_count;
  logic [3:0]  rd_count_s;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  errfield_counter dut_i (
    .clk(clk), .rst(rst), .field_done(field_done), .err_flags(err_flags),
    .crc_err(crc_err), .sens_n(sens_n), .crc_sens(crc_sens), .mode(mode),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_count(rd_count)
  );

  errfield_counter #(.CNT_W(4)) dut_sat_i (
    .clk(clk), .rst(rst), .field_done(field_done), .err_flags(err_flags),
    .crc_err(crc_err), .sens_n(sens_n), .crc_sens(crc_sens), .mode(mode),
    .rd_req(rd_req), .rd_valid(rd_valid_s), .rd_count(rd_count_s)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic field(input logic [15:0] f, input logic c);
    @(negedge clk);
    field_done = 1'b1; err_flags = f; crc_err = c;
    @(negedge clk);
    field_done = 1'b0; err_flags = '0; crc_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(output logic [23:0] v);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    v = rd_count;
  endtask

  task automatic t_reset;
    check("R1 valid", {23'd0, rd_valid}, 24'd0);
    check("R1 data", rd_count, 24'd0);
  endtask

  task automatic t_count;
    logic [23:0] v;
    sens_n = ~16'h0001;
    field(16'h0001, 1'b0);
    do_read(v); check("R2 single flag", v, 24'd1);
    sens_n = 16'h0000;
    field(16'hFFFF, 1'b0);
    do_read(v); check("R2 many flags one step", v, 24'd2);
    sens_n = ~16'h0001;
    field(16'h0002, 1'b0);
    do_read(v); check("R3 masked flag", v, 24'd2);
    sens_n = ~16'h8000;
    field(16'h8000, 1'b0);
    do_read(v); check("R3 top flag", v, 24'd3);
  endtask

  task automatic t_crc;
    logic [23:0] v;
    sens_n = 16'hFFFF;
    crc_sens = 1'b1;
    field(16'h0000, 1'b1);
    do_read(v); check("R4 crc enabled", v, 24'd4);
    crc_sens = 1'b0;
    field(16'hFFFF, 1'b1);
    do_read(v); check("R4 crc masked", v, 24'd4);
  endtask

  task automatic t_nostrobe;
    logic [23:0] v;
    sens_n = 16'h0000;
    @(negedge clk);
    err_flags = 16'hFFFF; crc_err = 1'b1;
    repeat (5) @(negedge clk);
    err_flags = '0; crc_err = 1'b0;
    do_read(v); check("R5 no strobe", v, 24'd4);
  endtask

  task automatic t_hold;
    logic [23:0] v;
    mode = 2'b01;
    field(16'h0001, 1'b0);
    do_read(v); check("R6 hold zero", v, 24'd0);
    mode = 2'b00;
    field(16'h0001, 1'b0);
    field(16'h0001, 1'b0);
    do_read(v); check("R6 free after hold", v, 24'd2);
  endtask

  task automatic t_rdclr;
    logic [23:0] v;
    mode = 2'b10;
    field(16'h0004, 1'b0);
    do_read(v); check("R7 read returns count", v, 24'd3);
    do_read(v); check("R7 cleared", v, 24'd0);
  endtask

  task automatic t_freeze;
    logic [23:0] v;
    mode = 2'b00;
    field(16'h0001, 1'b0);
    field(16'h0001, 1'b0);
    mode = 2'b11;
    field(16'h0001, 1'b0);
    do_read(v); check("R8 frozen", v, 24'd2);
    do_read(v); check("R8 read no clear", v, 24'd2);
  endtask

  task automatic t_readport;
    logic [23:0] v;
    do_read(v);
    check("R10 valid pulse", {23'd0, rd_valid}, 24'd1);
    @(negedge clk);
    check("R10 valid drops", {23'd0, rd_valid}, 24'd0);
    check("R10 data held", rd_count, v);
  endtask

  task automatic t_sat;
    logic [23:0] v;
    mode = 2'b00;
    for (int i = 0; i < 20; i++) field(16'h0001, 1'b0);
    do_read(v);
    check("R9 main count", v, 24'd22);
    check("R9 saturated", {20'd0, rd_count_s}, 24'd15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_crc();
    t_nostrobe();
    t_hold();
    t_rdclr();
    t_freeze();
    t_readport();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule